// File: doc/BRIEF.md
# Crosstalk Margin Sweep Sequencer for a Two-Phase Channel Array

This block drives a 3 by 65 grid of pulse-link transmitters while a crosstalk margin test runs. Every channel belongs to one of two time slots, laid out as a checkerboard, so neighbours never fire together. The middle channel of the grid carries an externally supplied data stream. Every other channel carries bits from one of four free-running 7-bit pseudo-random generators.

A sweep starts with only the centre column enabled. After each fixed observation window, one more column of three channels is switched on, alternating right and left of the centre. During every window the received bit of the centre link is compared with the bit that was sent. A step passes only when its whole window is free of mismatches. The sweep stops at the first failing step and reports the largest channel count that ran clean.

A separate register holds one of fifteen transmit power levels for the drivers. The window length is a programmable cycle count, so short windows can be used in place of long real-time ones.

Top module: `xtalk_sweep_seq`

## Requirements
- R1: Channel index is row*65+col, and its slot is (row+col) mod 2. A slot bit is 0 in the first cycle after reset and toggles every cycle. `tx_strobe` is high exactly for the active channels whose slot equals the slot bit.
- R2: An inactive channel drives 0 on `tx_strobe` and `tx_bit`. While no sweep runs, no channel is active.
- R3: The centre channel (row 1, column 32, index 97) sends on `tx_bit` the value of `center_data` sampled at the previous clock edge.
- R4: The other channels take their bits from generator (col mod 4), at bit position row. Each generator shifts left with new LSB = bit6 XOR bit5. Generator g loads 1<<g in reset and steps every cycle.
- R5: Step n of a sweep enables all rows of n columns. Columns join in the order 32, 33, 31, 34, 30, and so on. Between cycles the column count stays the same or grows by one.
- R6: Each step lasts `win_len` cycles (0 counts as 1). In every one of those cycles `rx_data` is compared with `center_data` as sampled one cycle earlier. A step with any mismatch fails, and a failing step still runs its full window.
- R7: The sweep ends after the first failing step or after step 65. `best_count` is 3 times the number of passing steps, so a full pass gives 195. `sweep_done` rises and `sweep_busy` falls.
- R8: Bit i of `step_tested` is set once step i+1 has completed, and bit i of `step_passed` is set if that step passed. Both vectors clear at the start of a sweep.
- R9: `pwr_level` resets to 0 and is loaded from `pwr_din` when `pwr_wr` is high. A value above 14 is stored as 14, giving fifteen levels. Without a write the level holds.
- R10: After reset the block is idle: not busy, not done, `best_count` 0, and both result vectors 0. A `sweep_start` pulse that arrives while a sweep runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_start | input | 1 | Begin a sweep when idle or done |
| win_len | input | 24 | Observation window per step, in cycles |
| pwr_wr | input | 1 | Load the power level |
| pwr_din | input | 4 | Requested power level |
| center_data | input | 1 | External data for the centre channel |
| rx_data | input | 1 | Centre receiver output |
| ch_active | output | 195 | Per-channel enable |
| tx_strobe | output | 195 | Per-channel fire in the current slot |
| tx_bit | output | 195 | Per-channel data bit |
| pwr_level | output | 4 | Current transmit power level |
| sweep_busy | output | 1 | Sweep in progress |
| sweep_done | output | 1 | Sweep finished, results valid |
| best_count | output | 8 | Largest error-free active channel count |
| step_tested | output | 65 | Steps completed |
| step_passed | output | 65 | Steps that ran clean |

## Verification
Properties checked on every cycle cover the following:
- the slot bit alternates;
- the array stays dark while idle;
- the centre channel stays enabled during a sweep;
- the column count grows by at most one and stays within range;
- completed steps are never forgotten;
- the generators never lock at zero;
- the power level stays capped and holds without a write.

Some behaviour can only be shown by the bench's scenarios. These include the exact activation order and checkerboard strobe pattern, the bit sent on each channel, and the length of each window. They also include the stop point under crosstalk tied to channel count and power level, and under a forced single error on the first or last step. Finally, they show that a start pulse mid-sweep is ignored.

// File: rtl/xts_pkg.sv
package xts_pkg;

    localparam int LFSR_W = 7;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_RUN  = 2'd1,
        SW_DONE = 2'd2
    } sweep_state_e;

    // Outcome of the current observation window
    typedef struct packed {
        logic close;   // last cycle of the window
        logic clean;   // no mismatch seen in the window
    } verdict_t;

    // x^7 + x^6 + 1, shift toward MSB, feedback into LSB
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_seed(input int g);
        return LFSR_W'(1) << (g % LFSR_W);
    endfunction

    // Order in which a column joins the active region
    function automatic int col_rank(input int c, input int mid);
        if (c == mid)      return 0;
        else if (c > mid)  return 2 * (c - mid) - 1;
        else               return 2 * (mid - c);
    endfunction

    // Checkerboard slot of a channel
    function automatic logic chan_phase(input int r, input int c);
        return ((r + c) % 2) != 0;
    endfunction

endpackage

// File: rtl/xts_prbs_bank.sv
module xts_prbs_bank
    import xts_pkg::*;
#(
    parameter int NGEN = 4,
    parameter int ROWS = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [NGEN-1:0][ROWS-1:0]  taps
);

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        logic [LFSR_W-1:0] s;

        always_ff @(posedge clk) begin
            if (rst) s <= lfsr_seed(g);
            else     s <= lfsr_step(s);
        end

        assign taps[g] = s[ROWS-1:0];

        // Generator must never fall into the all-zero lock state
        assert_lfsr_live_R4: assert property (@(posedge clk) disable iff (rst)
            s != '0);
    end

endmodule

// File: rtl/xts_chan_map.sv
module xts_chan_map
    import xts_pkg::*;
#(
    parameter  int ROWS   = 3,
    parameter  int COLS   = 65,
    parameter  int NGEN   = 4,
    parameter  int STEP_W = 7,
    localparam int NCH    = ROWS * COLS
) (
    input  logic                      running,
    input  logic [STEP_W-1:0]         ncols,
    input  logic                      slot,
    input  logic                      center_bit,
    input  logic [NGEN-1:0][ROWS-1:0] gen_taps,
    output logic [NCH-1:0]            ch_active,
    output logic [NCH-1:0]            tx_strobe,
    output logic [NCH-1:0]            tx_bit
);

    localparam int CROW = ROWS / 2;
    localparam int CCOL = COLS / 2;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int   CH   = r * COLS + c;
            localparam int   RANK = col_rank(c, CCOL);
            localparam logic PH   = chan_phase(r, c);
            logic src;

            if (r == CROW && c == CCOL) begin : g_ctr
                assign src = center_bit;
            end else begin : g_prbs
                assign src = gen_taps[c % NGEN][r];
            end

            assign ch_active[CH] = running && (ncols > STEP_W'(RANK));
            assign tx_strobe[CH] = ch_active[CH] && (slot == PH);
            assign tx_bit[CH]    = ch_active[CH] && src;
        end
    end

endmodule

// File: rtl/xts_step_ctrl.sv
module xts_step_ctrl
    import xts_pkg::*;
#(
    parameter  int ROWS   = 3,
    parameter  int COLS   = 65,
    parameter  int WIN_W  = 24,
    parameter  int RX_LAT = 1,
    localparam int STEP_W = $clog2(COLS + 1),
    localparam int CNT_W  = $clog2(ROWS * COLS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              cdata_q,
    input  logic              rx_data,
    output logic              running,
    output logic              done,
    output logic [STEP_W-1:0] ncols,
    output logic [CNT_W-1:0]  best,
    output logic [COLS-1:0]   tested,
    output logic [COLS-1:0]   passed
);

    sweep_state_e      state;
    logic [WIN_W-1:0]  wcnt;
    logic [WIN_W-1:0]  win_last;
    logic              err_acc;
    logic              exp_bit;
    logic              mismatch;
    verdict_t          vd;

    // Expected-data delay line: stage 0 is the already registered input
    logic [RX_LAT-1:0] line;
    assign line[0] = cdata_q;
    for (genvar i = 1; i < RX_LAT; i++) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) line[i] <= 1'b0;
            else     line[i] <= line[i-1];
        end
    end
    assign exp_bit  = line[RX_LAT-1];
    assign mismatch = rx_data ^ exp_bit;

    assign win_last = (win_len == '0) ? '0 : win_len - 1'b1;

    always_comb begin
        vd.close = (state == SW_RUN) && (wcnt == win_last);
        vd.clean = !(err_acc || mismatch);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SW_IDLE;
            ncols   <= '0;
            wcnt    <= '0;
            err_acc <= 1'b0;
            best    <= '0;
            tested  <= '0;
            passed  <= '0;
        end else begin
            unique case (state)
                SW_IDLE, SW_DONE: begin
                    if (start) begin
                        state   <= SW_RUN;
                        ncols   <= STEP_W'(1);
                        wcnt    <= '0;
                        err_acc <= 1'b0;
                        best    <= '0;
                        tested  <= '0;
                        passed  <= '0;
                    end
                end
                SW_RUN: begin
                    if (vd.close) begin
                        wcnt                  <= '0;
                        err_acc               <= 1'b0;
                        tested[ncols - 1'b1]  <= 1'b1;
                        passed[ncols - 1'b1]  <= vd.clean;
                        if (!vd.clean) begin
                            state <= SW_DONE;
                            best  <= CNT_W'(ROWS * (int'(ncols) - 1));
                        end else if (ncols == STEP_W'(COLS)) begin
                            state <= SW_DONE;
                            best  <= CNT_W'(ROWS * COLS);
                        end else begin
                            ncols <= ncols + 1'b1;
                        end
                    end else begin
                        wcnt    <= wcnt + 1'b1;
                        err_acc <= err_acc | mismatch;
                    end
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    assign running = (state == SW_RUN);
    assign done    = (state == SW_DONE);

    assert_ncols_range_R5: assert property (@(posedge clk) disable iff (rst)
        running |-> (ncols >= STEP_W'(1)) && (ncols <= STEP_W'(COLS)));

    assert_ncols_step_R5: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |->
            ((ncols == $past(ncols)) || (ncols == $past(ncols) + 1'b1)));

    assert_tested_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> ((tested & $past(tested)) == $past(tested)));

endmodule

// File: rtl/xts_power_reg.sv
module xts_power_reg #(
    parameter  int LEVELS = 15,
    localparam int PW     = $clog2(LEVELS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] level
);

    localparam logic [PW-1:0] TOP = PW'(LEVELS - 1);

    always_ff @(posedge clk) begin
        if (rst)     level <= '0;
        else if (wr) level <= (din > TOP) ? TOP : din;
    end

    assert_pwr_cap_R9: assert property (@(posedge clk) disable iff (rst)
        level <= TOP);

    assert_pwr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(wr) |-> $stable(level));

endmodule

// File: rtl/xtalk_sweep_seq.sv
module xtalk_sweep_seq
    import xts_pkg::*;
#(
    parameter  int ROWS       = 3,
    parameter  int COLS       = 65,
    parameter  int NGEN       = 4,
    parameter  int WIN_W      = 24,
    parameter  int RX_LAT     = 1,
    parameter  int PWR_LEVELS = 15,
    localparam int NCH        = ROWS * COLS,
    localparam int PW         = $clog2(PWR_LEVELS),
    localparam int CNT_W      = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sweep_start,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              pwr_wr,
    input  logic [PW-1:0]     pwr_din,
    input  logic              center_data,
    input  logic              rx_data,
    output logic [NCH-1:0]    ch_active,
    output logic [NCH-1:0]    tx_strobe,
    output logic [NCH-1:0]    tx_bit,
    output logic [PW-1:0]     pwr_level,
    output logic              sweep_busy,
    output logic              sweep_done,
    output logic [CNT_W-1:0]  best_count,
    output logic [COLS-1:0]   step_tested,
    output logic [COLS-1:0]   step_passed
);

    localparam int STEP_W = $clog2(COLS + 1);
    localparam int CENTER = (ROWS / 2) * COLS + COLS / 2;

    logic                      slot;
    logic                      center_q;
    logic [STEP_W-1:0]         ncols;
    logic [NGEN-1:0][ROWS-1:0] gen_taps;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= 1'b0;
            center_q <= 1'b0;
        end else begin
            slot     <= ~slot;
            center_q <= center_data;
        end
    end

    xts_prbs_bank #(.NGEN(NGEN), .ROWS(ROWS)) u_prbs (
        .clk  (clk),
        .rst  (rst),
        .taps (gen_taps)
    );

    xts_step_ctrl #(.ROWS(ROWS), .COLS(COLS), .WIN_W(WIN_W), .RX_LAT(RX_LAT)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (sweep_start),
        .win_len (win_len),
        .cdata_q (center_q),
        .rx_data (rx_data),
        .running (sweep_busy),
        .done    (sweep_done),
        .ncols   (ncols),
        .best    (best_count),
        .tested  (step_tested),
        .passed  (step_passed)
    );

    xts_chan_map #(.ROWS(ROWS), .COLS(COLS), .NGEN(NGEN), .STEP_W(STEP_W)) u_map (
        .running    (sweep_busy),
        .ncols      (ncols),
        .slot       (slot),
        .center_bit (center_q),
        .gen_taps   (gen_taps),
        .ch_active  (ch_active),
        .tx_strobe  (tx_strobe),
        .tx_bit     (tx_bit)
    );

    xts_power_reg #(.LEVELS(PWR_LEVELS)) u_pwr (
        .clk   (clk),
        .rst   (rst),
        .wr    (pwr_wr),
        .din   (pwr_din),
        .level (pwr_level)
    );

    assert_slot_alt_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (slot != $past(slot)));

    assert_idle_dark_R2: assert property (@(posedge clk) disable iff (rst)
        !sweep_busy |-> ((ch_active == '0) && (tx_strobe == '0)));

    assert_center_on_R3: assert property (@(posedge clk) disable iff (rst)
        sweep_busy |-> ch_active[CENTER]);

endmodule

// File: tb/sim_xtalk_sweep_seq.sv
`timescale 1ns/1ps
module sim_xtalk_sweep_seq;

    localparam int ROWS = 3, COLS = 65, NCH = 195, NGEN = 4;
    localparam int WIN_W = 24, PW = 4, CW = 8;
    localparam int CTR = 1 * COLS + 32;

    logic clk = 1'b0, rst = 1'b1;
    logic sweep_start = 1'b0, pwr_wr = 1'b0, center_data = 1'b0, rx_data = 1'b0;
    logic [WIN_W-1:0] win_len = '0;
    logic [PW-1:0]    pwr_din = '0;
    logic [NCH-1:0]   ch_active, tx_strobe, tx_bit;
    logic [PW-1:0]    pwr_level;
    logic             sweep_busy, sweep_done;
    logic [CW-1:0]    best_count;
    logic [COLS-1:0]  step_tested, step_passed;

    int n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    xtalk_sweep_seq u0 (
        .clk(clk), .rst(rst), .sweep_start(sweep_start), .win_len(win_len),
        .pwr_wr(pwr_wr), .pwr_din(pwr_din), .center_data(center_data), .rx_data(rx_data),
        .ch_active(ch_active), .tx_strobe(tx_strobe), .tx_bit(tx_bit),
        .pwr_level(pwr_level), .sweep_busy(sweep_busy), .sweep_done(sweep_done),
        .best_count(best_count), .step_tested(step_tested), .step_passed(step_passed)
    );

    // Independent models of slot count and generators (R1, R4)
    int unsigned bcyc;
    logic [6:0]  lf [NGEN];
    always @(posedge clk) begin
        if (rst) begin
            bcyc <= 0;
            for (int g = 0; g < NGEN; g++) lf[g] <= 7'(1 << g);
        end else begin
            bcyc <= bcyc + 1;
            for (int g = 0; g < NGEN; g++) lf[g] <= {lf[g][5:0], lf[g][6] ^ lf[g][5]};
        end
    end

    function automatic int b_rank(input int c);
        if (c == 32) return 0;
        if (c > 32)  return 2 * (c - 32) - 1;
        return 2 * (32 - c);
    endfunction

    // Bench crosstalk model: tolerable active channels per power level
    function automatic int b_allowed(input int lvl);
        return 195 - 12 * lvl;
    endfunction

    function automatic int b_fit(input int lvl, input int k);
        int nf;
        nf = b_allowed(lvl) / 3;
        if (nf > 65) nf = 65;
        if (nf < 0)  nf = 0;
        if (k > 0 && k - 1 < nf) nf = k - 1;
        return nf;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    bit mon_en = 1'b0, was_busy = 1'b0;
    int prev_n = 0, run_len = 0, lcur = 1, force_k = 0;
    int m_r1 = 0, m_r2 = 0, m_r3 = 0, m_r4 = 0, m_r5 = 0, m_r6 = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            int n;
            bit err;
            n = $countones(ch_active) / 3;
            if (sweep_busy) begin
                if (n < 1) m_r5++;
                if (prev_n != 0 && n != prev_n && n != prev_n + 1) m_r5++;
                if (n != prev_n) begin
                    if (prev_n != 0 && run_len != lcur) m_r6++;
                    run_len = 1;
                end else begin
                    run_len++;
                end
            end else begin
                if (ch_active != '0 || tx_strobe != '0 || tx_bit != '0) m_r2++;
                if (was_busy && run_len != lcur) m_r6++;
            end
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    int ch;
                    bit act_e;
                    ch = r * COLS + c;
                    act_e = sweep_busy && (b_rank(c) < n);
                    if (ch_active[ch] != act_e) m_r5++;
                    if (tx_strobe[ch] != (ch_active[ch] && (((r + c) % 2) == int'(bcyc % 2)))) m_r1++;
                    if (!ch_active[ch]) begin
                        if (tx_bit[ch]) m_r2++;
                    end else if (ch == CTR) begin
                        if (tx_bit[ch] != center_data) m_r3++;
                    end else if (tx_bit[ch] != lf[c % NGEN][r]) begin
                        m_r4++;
                    end
                end
            end
            err = sweep_busy && ((3 * n > b_allowed(int'(pwr_level))) ||
                                 (n == force_k && n != prev_n));
            rx_data     = center_data ^ err;
            center_data = 1'($urandom % 2);
            prev_n      = sweep_busy ? n : 0;
            was_busy    = sweep_busy;
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic write_pwr(input int v);
        pwr_din = PW'(v);
        pwr_wr  = 1'b1;
        @(negedge clk);
        pwr_wr  = 1'b0;
    endtask

    task automatic run_sweep(input int lvl, input int L, input int k, input bit poke);
        int guard, nres;
        logic [COLS-1:0] epass, etest;
        write_pwr(lvl);
        lcur = (L == 0) ? 1 : L;
        force_k = k;
        m_r1 = 0; m_r2 = 0; m_r3 = 0; m_r4 = 0; m_r5 = 0; m_r6 = 0;
        run_len = 0;
        win_len = WIN_W'(L);
        sweep_start = 1'b1;
        @(negedge clk);
        sweep_start = 1'b0;
        if (poke) begin
            repeat (9) @(negedge clk);
            sweep_start = 1'b1;
            @(negedge clk);
            sweep_start = 1'b0;
        end
        guard = 0;
        while (!sweep_done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        nres = b_fit(lvl, k);
        for (int i = 0; i < COLS; i++) begin
            epass[i] = (i < nres);
            etest[i] = (i <= nres);
        end
        chk(int'(best_count) == 3 * nres, "R7 best count", best_count, 3 * nres);
        chk(sweep_done && !sweep_busy, "R7 done/busy", {sweep_done, sweep_busy}, 2);
        chk(step_passed == epass, "R8 passed steps", $countones(step_passed), nres);
        chk(step_tested == etest, "R8 tested steps", $countones(step_tested), $countones(etest));
        chk(m_r1 == 0, "R1 strobe slot", m_r1, 0);
        chk(m_r2 == 0, "R2 inactive quiet", m_r2, 0);
        chk(m_r3 == 0, "R3 centre bit", m_r3, 0);
        chk(m_r4 == 0, "R4 generator bits", m_r4, 0);
        chk(m_r5 == 0, "R5 activation order", m_r5, 0);
        chk(m_r6 == 0, "R6 window length", m_r6, 0);
        if (poke) chk(m_r5 == 0 && int'(best_count) == 3 * nres, "R10 start ignored while busy", best_count, 3 * nres);
    endtask

    initial begin
        int lvl, L, k;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!sweep_busy && !sweep_done, "R10 reset idle", {sweep_busy, sweep_done}, 0);
        chk(best_count == '0 && step_tested == '0 && step_passed == '0, "R10 reset results", best_count, 0);
        chk(ch_active == '0 && tx_strobe == '0, "R2 reset dark", $countones(ch_active), 0);
        chk(pwr_level == '0, "R9 reset level", pwr_level, 0);
        // R9 clamp, load and hold
        write_pwr(15);
        chk(pwr_level == 4'd14, "R9 clamp", pwr_level, 14);
        write_pwr(9);
        chk(pwr_level == 4'd9, "R9 load", pwr_level, 9);
        pwr_din = 4'd3;
        @(negedge clk);
        chk(pwr_level == 4'd9, "R9 hold without write", pwr_level, 9);
        // Directed sweeps
        run_sweep(0, 3, 0, 1'b1);   // full pass, start poked mid-sweep
        run_sweep(14, 1, 0, 1'b0);  // crosstalk stop at 27
        run_sweep(14, 0, 0, 1'b0);  // zero window acts as one cycle
        run_sweep(0, 2, 1, 1'b0);   // first step fails
        run_sweep(0, 1, 65, 1'b0);  // last step fails
        run_sweep(3, 4, 10, 1'b0);  // forced error before crosstalk limit
        // Random sweeps
        for (int i = 0; i < 5; i++) begin
            lvl = $urandom_range(0, 14);
            L   = $urandom_range(0, 5);
            k   = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 65) : 0;
            run_sweep(lvl, L, k, 1'b0);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule